// File: doc/BRIEF.md
# Cartridge PRG Bank-Switching Address Decoder

This block sits on the cartridge side of an 8-bit console CPU bus. From each 16-bit CPU address it works out whether the access goes to program ROM, to work RAM or to nothing. It then produces the physical ROM or RAM address for that access. Two bank registers, loaded by CPU writes into the ROM space, choose which 4 KiB pieces of a 128 KiB ROM appear in two switchable windows. One of those registers also carries the nametable mirroring flag.

The 8 KiB work RAM is not placed at one contiguous range. It is spread over three windows, and two of them sit inside the upper ROM space. One switchable 4 KiB bank is also split: its first 3 KiB appear at 0xC000 and its last 1 KiB appears at 0x6C00. The rest of the upper space shows a fixed image of the last 32 KiB of ROM.

Decode is purely combinational from the CPU address. The registers change on the rising clock edge when a write strobe is present.

Top module: `prg_bank_decoder`

## Requirements
- R1: After a synchronous reset, both bank registers read as zero and `mirror_horiz` is 0 (vertical). A read at 0x7000 then gives ROM address 0x10000, and a read at 0xC000 gives ROM address 0x00000.
- R2: A write to 0x8000–0x8FFF loads the low-window register. Data bits 2:0 become the low bank and bit 3 becomes `mirror_horiz` (0 vertical, 1 horizontal). Both are visible from the cycle after the write edge.
- R3: A write to 0x9000–0x9FFF loads the split-bank register from data bits 3:0.
- R4: A read at 0x7000–0x7FFF asserts `rom_sel` with ROM address 0x10000 + lowbank·0x1000 + (addr − 0x7000).
- R5: A read at 0xC000–0xCBFF gives ROM address splitbank·0x1000 + (addr − 0xC000). A read at 0x6C00–0x6FFF gives splitbank·0x1000 + 0xC00 + (addr − 0x6C00).
- R6: A read at 0x8000–0xB7FF or 0xD800–0xFFFF gives ROM address 0x18000 + (addr − 0x8000), whatever the registers hold.
- R7: RAM windows map as follows: 0x6000–0x6BFF to RAM 0x0000–0x0BFF, 0xB800–0xBFFF to RAM 0x0C00–0x13FF, and 0xCC00–0xD7FF to RAM 0x1400–0x1FFF. `ram_sel` is set on a read or a write there, `ram_we` only on a write, and `rom_sel` is never set. `rom_sel` and `ram_sel` are never both set.
- R8: A write into any RAM window leaves both bank registers and `mirror_horiz` unchanged.
- R9: An access at 0x0000–0x5FFF asserts neither `rom_sel` nor `ram_sel`, so the read data seen by the CPU is 0x00.
- R10: Writes to 0x6C00–0x7FFF, 0xA000–0xB7FF, 0xC000–0xCBFF and 0xD800–0xFFFF change no register and assert neither `ram_we` nor `rom_sel`. `rom_sel` is only ever set on a read.
- R11: Data bits above the register field are ignored. Writing 0xFA at 0x8000 gives low bank 2 with horizontal mirroring, and writing 0xF5 at 0x9FFF gives split bank 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| rom_addr | output | 17 | PRG ROM byte address |
| rom_sel | output | 1 | ROM read select |
| ram_addr | output | 13 | Work RAM byte address |
| ram_sel | output | 1 | Work RAM select |
| ram_we | output | 1 | Work RAM write enable |
| mirror_horiz | output | 1 | Mirroring flag, 1 = horizontal |

## Verification
A bank register that holds the wrong value can only be seen through ROM addresses in the 0x7000 window or in the two split windows. It shows on the first read there after the faulty write, one cycle after the write edge. A decode error on a window boundary shows at once on the selects and addresses, in the same cycle as the access. For that reason the bench probes the first and last byte of every window. It also reads back both windows after every stimulus that is meant to leave the registers alone.

// File: rtl/prg_dec_pkg.sv
package prg_dec_pkg;
    localparam int CPU_AW     = 16;
    localparam int DATA_W     = 8;
    localparam int ROM_AW     = 17;
    localparam int RAM_AW     = 13;
    localparam int BANK_OFS_W = 12;
    localparam int LO_BANK_W  = 3;
    localparam int HI_BANK_W  = 4;

    typedef struct packed {
        logic [LO_BANK_W-1:0] lo_bank;
        logic                 mirror_h;
        logic [HI_BANK_W-1:0] hi_bank;
    } bank_state_t;

    typedef struct packed {
        logic              ram_hit;
        logic              rom_hit;
        logic              lo_reg_hit;
        logic              hi_reg_hit;
        logic [ROM_AW-1:0] rom_addr;
        logic [RAM_AW-1:0] ram_addr;
    } decode_t;
endpackage

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
    import prg_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [DATA_W-1:0] wdata,
    output bank_state_t       state
);
    bank_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (lo_we) begin
            state_d.lo_bank  = wdata[LO_BANK_W-1:0];
            state_d.mirror_h = wdata[LO_BANK_W];
        end
        if (hi_we) begin
            state_d.hi_bank = wdata[HI_BANK_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign state = state_q;

    assert_lo_load_R2: assert property (@(posedge clk) disable iff (rst)
        lo_we |=> (state_q.lo_bank == $past(wdata[LO_BANK_W-1:0]))
                  && (state_q.mirror_h == $past(wdata[LO_BANK_W])));

    assert_hi_load_R3: assert property (@(posedge clk) disable iff (rst)
        hi_we |=> (state_q.hi_bank == $past(wdata[HI_BANK_W-1:0])));

    assert_hold_without_write_R8: assert property (@(posedge clk) disable iff (rst)
        (!lo_we && !hi_we) |=> $stable(state_q));
endmodule

// File: rtl/prg_window_decode.sv
module prg_window_decode
    import prg_dec_pkg::*;
(
    input  logic [CPU_AW-1:0] addr,
    input  bank_state_t       state,
    output decode_t           dec
);
    localparam logic [ROM_AW-1:0] LO_REGION_BASE = ROM_AW'(17'h10000);
    localparam logic [ROM_AW-1:0] FIXED_BASE     = ROM_AW'(17'h18000);

    logic [ROM_AW-1:0] ofs_fixed;
    logic [ROM_AW-1:0] split_bank_base;
    logic [ROM_AW-1:0] lo_bank_base;
    logic [ROM_AW-1:0] addr_ext;

    always_comb begin
        addr_ext        = ROM_AW'(addr);
        ofs_fixed       = FIXED_BASE + (addr_ext - ROM_AW'(17'h08000));
        split_bank_base = ROM_AW'(state.hi_bank) << BANK_OFS_W;
        lo_bank_base    = LO_REGION_BASE + (ROM_AW'(state.lo_bank) << BANK_OFS_W);

        dec            = '0;
        dec.lo_reg_hit = (addr >= 16'h8000) && (addr <= 16'h8FFF);
        dec.hi_reg_hit = (addr >= 16'h9000) && (addr <= 16'h9FFF);

        // RAM windows take priority over every ROM window
        if (addr >= 16'h6000 && addr <= 16'h6BFF) begin
            dec.ram_hit  = 1'b1;
            dec.ram_addr = RAM_AW'(addr - 16'h6000);
        end else if (addr >= 16'hB800 && addr <= 16'hBFFF) begin
            dec.ram_hit  = 1'b1;
            dec.ram_addr = RAM_AW'(addr - 16'hB800 + 16'h0C00);
        end else if (addr >= 16'hCC00 && addr <= 16'hD7FF) begin
            dec.ram_hit  = 1'b1;
            dec.ram_addr = RAM_AW'(addr - 16'hCC00 + 16'h1400);
        end else if (addr >= 16'h6C00 && addr <= 16'h6FFF) begin
            dec.rom_hit  = 1'b1;
            dec.rom_addr = split_bank_base + ROM_AW'(addr[BANK_OFS_W-1:0]);
        end else if (addr >= 16'h7000 && addr <= 16'h7FFF) begin
            dec.rom_hit  = 1'b1;
            dec.rom_addr = lo_bank_base + ROM_AW'(addr[BANK_OFS_W-1:0]);
        end else if (addr >= 16'hC000 && addr <= 16'hCBFF) begin
            dec.rom_hit  = 1'b1;
            dec.rom_addr = split_bank_base + ROM_AW'(addr[BANK_OFS_W-1:0]);
        end else if (addr >= 16'h8000) begin
            dec.rom_hit  = 1'b1;
            dec.rom_addr = ofs_fixed;
        end
    end
endmodule

// File: rtl/prg_bank_decoder.sv
module prg_bank_decoder
    import prg_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_sel,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_sel,
    output logic              ram_we,
    output logic              mirror_horiz
);
    bank_state_t state;
    decode_t     dec;
    logic        lo_we, hi_we;

    prg_window_decode u_decode (
        .addr  (cpu_addr),
        .state (state),
        .dec   (dec)
    );

    assign lo_we = cpu_wr && dec.lo_reg_hit && !dec.ram_hit;
    assign hi_we = cpu_wr && dec.hi_reg_hit && !dec.ram_hit;

    prg_bank_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .lo_we (lo_we),
        .hi_we (hi_we),
        .wdata (cpu_wdata),
        .state (state)
    );

    always_comb begin
        rom_sel      = cpu_rd && !cpu_wr && dec.rom_hit;
        ram_sel      = (cpu_rd || cpu_wr) && dec.ram_hit;
        ram_we       = cpu_wr && dec.ram_hit;
        rom_addr     = rom_sel ? dec.rom_addr : '0;
        ram_addr     = ram_sel ? dec.ram_addr : '0;
        mirror_horiz = state.mirror_h;
    end

    assert_sel_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rom_sel, ram_sel}));

    assert_we_in_ram_R7: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (cpu_wr && ram_sel && !rom_sel));

    assert_rom_read_only_R10: assert property (@(posedge clk) disable iff (rst)
        rom_sel |-> (cpu_rd && !cpu_wr));

    assert_ram_write_keeps_mirror_R8: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> $stable(mirror_horiz));

    assert_low_space_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr < 16'h6000) |-> (!rom_sel && !ram_sel));
endmodule

// File: tb/prg_bank_decoder_test.sv
module prg_bank_decoder_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_wr, cpu_rd;
    logic [16:0] rom_addr;
    logic        rom_sel;
    logic [12:0] ram_addr;
    logic        ram_sel, ram_we, mirror_horiz;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    prg_bank_decoder uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_addr(rom_addr), .rom_sel(rom_sel),
        .ram_addr(ram_addr), .ram_sel(ram_sel), .ram_we(ram_we),
        .mirror_horiz(mirror_horiz)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_wdata = 8'h00; cpu_addr = 16'h0000;
    endtask

    task automatic rd(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        #1;
    endtask

    task automatic rom_read(input string tag, input logic [15:0] a, input logic [16:0] exp);
        rd(a);
        chk({tag, " rom_sel"}, 32'(rom_sel), 32'd1);
        chk({tag, " ram_sel"}, 32'(ram_sel), 32'd0);
        chk({tag, " rom_addr"}, 32'(rom_addr), 32'(exp));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle(); idle();
        rst = 1'b0;
        chk("R1 mirror", 32'(mirror_horiz), 32'd0);
        rom_read("R1 low bank", 16'h7000, 17'h10000);
        rom_read("R1 split bank", 16'hC000, 17'h00000);
    endtask

    task automatic t_low_window();
        wr(16'h8000, 8'h02); idle();
        rom_read("R4 bank2 first", 16'h7000, 17'h12000);
        chk("R2 mirror vertical", 32'(mirror_horiz), 32'd0);
        wr(16'h8001, 8'h07); idle();
        rom_read("R4 bank7 last", 16'h7FFF, 17'h17FFF);
        wr(16'h8FFF, 8'h08); idle();
        chk("R2 mirror horizontal", 32'(mirror_horiz), 32'd1);
        rom_read("R2 bank0", 16'h7123, 17'h10123);
    endtask

    task automatic t_split_window();
        wr(16'h9000, 8'h0A); idle();
        rom_read("R5 C000", 16'hC000, 17'h0A000);
        rom_read("R5 CBFF", 16'hCBFF, 17'h0ABFF);
        rom_read("R5 6C00", 16'h6C00, 17'h0AC00);
        rom_read("R5 6FFF", 16'h6FFF, 17'h0AFFF);
        wr(16'h9800, 8'h0F); idle();
        rom_read("R3 bank15", 16'hC000, 17'h0F000);
    endtask

    task automatic t_fixed();
        rom_read("R6 8000", 16'h8000, 17'h18000);
        rom_read("R6 B7FF", 16'hB7FF, 17'h1B7FF);
        rom_read("R6 D800", 16'hD800, 17'h1D800);
        rom_read("R6 FFFF", 16'hFFFF, 17'h1FFFF);
        rom_read("R6 A000", 16'hA000, 17'h1A000);
    endtask

    task automatic ram_probe(input logic [15:0] a, input logic [12:0] exp);
        rd(a);
        chk("R7 read ram_sel", 32'(ram_sel), 32'd1);
        chk("R7 read ram_we", 32'(ram_we), 32'd0);
        chk("R7 read rom_sel", 32'(rom_sel), 32'd0);
        chk("R7 ram_addr", 32'(ram_addr), 32'(exp));
    endtask

    task automatic t_ram();
        ram_probe(16'h6000, 13'h0000);
        ram_probe(16'h6BFF, 13'h0BFF);
        ram_probe(16'hB800, 13'h0C00);
        ram_probe(16'hBFFF, 13'h13FF);
        ram_probe(16'hCC00, 13'h1400);
        ram_probe(16'hD7FF, 13'h1FFF);
        wr(16'hB800, 8'h33);
        chk("R7 write ram_we", 32'(ram_we), 32'd1);
        chk("R7 write ram_sel", 32'(ram_sel), 32'd1);
        chk("R7 write ram_addr", 32'(ram_addr), 32'h0C00);
        idle();
    endtask

    task automatic t_ram_writes_keep_regs();
        wr(16'h8000, 8'h0B); wr(16'h9000, 8'h06); idle();
        wr(16'h6000, 8'hFF); wr(16'h6BFF, 8'hFF); wr(16'hBFFF, 8'hFF);
        wr(16'hCC00, 8'hF0); wr(16'hD7FF, 8'hFF); idle();
        rom_read("R8 low bank kept", 16'h7000, 17'h13000);
        rom_read("R8 split bank kept", 16'hC000, 17'h06000);
        chk("R8 mirror kept", 32'(mirror_horiz), 32'd1);
    endtask

    task automatic t_unmapped();
        rd(16'h0000);
        chk("R9 0000 rom_sel", 32'(rom_sel), 32'd0);
        chk("R9 0000 ram_sel", 32'(ram_sel), 32'd0);
        rd(16'h5FFF);
        chk("R9 5FFF sel", 32'({rom_sel, ram_sel}), 32'd0);
        chk("R9 read data", 32'((rom_sel || ram_sel) ? 8'hAA : 8'h00), 32'd0);
        wr(16'h2000, 8'h5A);
        chk("R9 write sel", 32'({rom_sel, ram_sel, ram_we}), 32'd0);
        idle();
    endtask

    task automatic t_ignored_writes();
        wr(16'h8000, 8'h03); wr(16'h9000, 8'h05); idle();
        wr(16'h7000, 8'hFF);
        chk("R10 7000 strobes", 32'({rom_sel, ram_we}), 32'd0);
        wr(16'hC000, 8'hFF);
        chk("R10 C000 strobes", 32'({rom_sel, ram_we}), 32'd0);
        wr(16'h6C00, 8'hFF);
        chk("R10 6C00 strobes", 32'({rom_sel, ram_we}), 32'd0);
        wr(16'hFFFF, 8'hFF);
        wr(16'hA000, 8'hFF);
        wr(16'hD800, 8'hFF); idle();
        rom_read("R10 low bank kept", 16'h7000, 17'h13000);
        rom_read("R10 split bank kept", 16'hC000, 17'h05000);
        chk("R10 mirror kept", 32'(mirror_horiz), 32'd0);
    endtask

    task automatic t_upper_bits();
        wr(16'h8000, 8'hFA); wr(16'h9FFF, 8'hF5); idle();
        rom_read("R11 low bank 2", 16'h7000, 17'h12000);
        chk("R11 mirror", 32'(mirror_horiz), 32'd1);
        rom_read("R11 split bank 5", 16'h6C00, 17'h05C00);
    endtask

    task automatic t_reset_again();
        rst = 1'b1;
        idle(); idle();
        rst = 1'b0;
        chk("R1 mirror after reload", 32'(mirror_horiz), 32'd0);
        rom_read("R1 low bank after reload", 16'h7FFF, 17'h10FFF);
        rom_read("R1 split after reload", 16'h6FFF, 17'h00FFF);
    endtask

    initial begin
        cpu_addr = '0; cpu_wdata = '0; cpu_wr = 1'b0; cpu_rd = 1'b0; rst = 1'b1;
        t_reset();
        t_low_window();
        t_split_window();
        t_fixed();
        t_ram();
        t_ram_writes_keep_regs();
        t_unmapped();
        t_ignored_writes();
        t_upper_bits();
        t_reset_again();
        idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule